// File: doc/BRIEF.md
# Dual-Channel Synthesizer Divider Programming Loader

This block takes the three control pins of a serial programming link (serial clock, serial data and load strobe) and turns them into the divider settings of two frequency synthesizer channels. Data bits enter a 23-bit shift register, most significant bit first, one bit on each rising edge of the serial clock. When the load strobe rises, the two lowest bits of the captured word are decoded as an address. The address selects one of four holding registers: the reference divider or the main divider of channel A or channel B.

A reference word carries a 14-bit reference ratio and a 2-bit test-monitor selection. A main word carries an 11-bit program count, a 7-bit swallow count and three mode bits: prescaler modulus select, detector polarity and monitor-pin select. A word whose reference ratio or program count is below five is not written, and a sticky error flag is raised instead. The serial pins are sampled on the system clock and are expected to be already synchronized. Words may be loaded at any time, including while a channel is powered down.

Top module: `synth_prog_loader`

## Requirements
- R1: Word bits are taken on each low-to-high transition of `ser_clk`, first bit most significant. The last bit shifted in is word bit 0 and the first is word bit 22.
- R2: On a rise of `ser_le`, word bit 0 picks the channel (0 = A, 1 = B) and word bit 1 picks the register (0 = reference, 1 = main). Only the addressed register changes.
- R3: In a reference word, bit 2 goes to `x_test_sel[0]`, bit 3 goes to `x_test_sel[1]` and bits 17:4 give the reference ratio, LSB at bit 4. Bits 22:18 are ignored.
- R4: In a main word, bit 2 goes to the monitor select, bit 3 to the prescaler select and bit 4 to the polarity bit. Bits 11:5 give the swallow count (LSB at bit 5) and bits 22:12 give the program count (LSB at bit 12).
- R5: A reference word with a ratio below 5 leaves the addressed register unchanged and sets `cfg_err`.
- R6: A main word with a program count below 5 leaves the addressed register unchanged and sets `cfg_err`. Any swallow count from 0 to 127 is accepted.
- R7: A register is written at most once per rise of `ser_le`. Bits shifted while `ser_le` stays high are held until `ser_le` falls and rises again.
- R8: After reset, both reference ratios are 5, both program counts are 5, and the swallow counts, mode bits, test selects and `cfg_err` are 0.
- R9: Once set, `cfg_err` stays high until reset, even when later words are accepted.
- R10: The boundary values 5 and 16383 for the reference ratio, and 2047 for the program count, are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock (synchronized) |
| ser_dat | input | 1 | Serial data |
| ser_le | input | 1 | Load strobe; its rise commits the word |
| a_ref_ratio | output | 14 | Channel A reference ratio |
| a_test_sel | output | 2 | Channel A test-monitor selection |
| a_swallow | output | 7 | Channel A swallow count |
| a_program | output | 11 | Channel A program count |
| a_presc_hi | output | 1 | Channel A larger prescaler modulus |
| a_pol_inv | output | 1 | Channel A detector polarity |
| a_mon_sel | output | 1 | Channel A monitor-pin select |
| b_ref_ratio | output | 14 | Channel B reference ratio |
| b_test_sel | output | 2 | Channel B test-monitor selection |
| b_swallow | output | 7 | Channel B swallow count |
| b_program | output | 11 | Channel B program count |
| b_presc_hi | output | 1 | Channel B larger prescaler modulus |
| b_pol_inv | output | 1 | Channel B detector polarity |
| b_mon_sel | output | 1 | Channel B monitor-pin select |
| cfg_err | output | 1 | Sticky flag for a rejected word |

## Verification
A fault in the shift path or the address decode shows up on the first load as a field in the wrong place or a register in the wrong channel. The output is visible one system clock after the strobe is seen high. Faulty edge detection on the strobe shows up as a second write while the strobe is still high, which a word shifted during that window exposes at once. A wrong range check shows up either as a prohibited ratio on an output or as a flag that fails to rise or to stay high.

// File: rtl/synth_prog_loader.sv
module synth_prog_loader #(
  parameter int REF_W   = 14,
  parameter int SWL_W   = 7,
  parameter int PRG_W   = 11,
  parameter int MIN_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  output logic [REF_W-1:0] a_ref_ratio,
  output logic [1:0]       a_test_sel,
  output logic [SWL_W-1:0] a_swallow,
  output logic [PRG_W-1:0] a_program,
  output logic             a_presc_hi,
  output logic             a_pol_inv,
  output logic             a_mon_sel,
  output logic [REF_W-1:0] b_ref_ratio,
  output logic [1:0]       b_test_sel,
  output logic [SWL_W-1:0] b_swallow,
  output logic [PRG_W-1:0] b_program,
  output logic             b_presc_hi,
  output logic             b_pol_inv,
  output logic             b_mon_sel,
  output logic             cfg_err
);
  localparam int WORD_W = 5 + SWL_W + PRG_W;
  localparam int REF_LO = 4;
  localparam int SWL_LO = 5;
  localparam int PRG_LO = SWL_LO + SWL_W;

  logic [WORD_W-1:0] sr_q;
  logic sclk_q, le_q;

  always_ff @(posedge clk) begin
    sclk_q <= ser_clk;
    le_q   <= ser_le;
  end

  wire shift_en = ser_clk & ~sclk_q;
  wire load_en  = ser_le & ~le_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], ser_dat};
  end

  wire             w_chan = sr_q[0];
  wire             w_main = sr_q[1];
  wire [REF_W-1:0] w_ref  = sr_q[REF_LO +: REF_W];
  wire [SWL_W-1:0] w_swl  = sr_q[SWL_LO +: SWL_W];
  wire [PRG_W-1:0] w_prg  = sr_q[PRG_LO +: PRG_W];
  wire ref_ok  = w_ref >= REF_W'(MIN_DIV);
  wire prg_ok  = w_prg >= PRG_W'(MIN_DIV);
  wire word_ok = w_main ? prg_ok : ref_ok;

  logic [1:0][REF_W-1:0] ref_q;
  logic [1:0][1:0]       tst_q;
  logic [1:0][SWL_W-1:0] swl_q;
  logic [1:0][PRG_W-1:0] prg_q;
  logic [1:0][2:0]       mode_q;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    wire hit = load_en && word_ok && (w_chan == 1'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_q[c]  <= REF_W'(MIN_DIV);
        tst_q[c]  <= '0;
        swl_q[c]  <= '0;
        prg_q[c]  <= PRG_W'(MIN_DIV);
        mode_q[c] <= '0;
      end else if (hit && !w_main) begin
        ref_q[c] <= w_ref;
        tst_q[c] <= sr_q[3:2];
      end else if (hit && w_main) begin
        swl_q[c]  <= w_swl;
        prg_q[c]  <= w_prg;
        mode_q[c] <= sr_q[4:2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   cfg_err <= 1'b0;
    else if (load_en && !word_ok) cfg_err <= 1'b1;
  end

  assign a_ref_ratio = ref_q[0];
  assign a_test_sel  = tst_q[0];
  assign a_swallow   = swl_q[0];
  assign a_program   = prg_q[0];
  assign a_mon_sel   = mode_q[0][0];
  assign a_presc_hi  = mode_q[0][1];
  assign a_pol_inv   = mode_q[0][2];
  assign b_ref_ratio = ref_q[1];
  assign b_test_sel  = tst_q[1];
  assign b_swallow   = swl_q[1];
  assign b_program   = prg_q[1];
  assign b_mon_sel   = mode_q[1][0];
  assign b_presc_hi  = mode_q[1][1];
  assign b_pol_inv   = mode_q[1][2];
endmodule

// File: rtl/synth_prog_loader_chk.sv
module synth_prog_loader_chk #(
  parameter int REF_W   = 14,
  parameter int SWL_W   = 7,
  parameter int PRG_W   = 11,
  parameter int MIN_DIV = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_le,
  input logic [REF_W-1:0] a_ref_ratio,
  input logic [REF_W-1:0] b_ref_ratio,
  input logic [PRG_W-1:0] a_program,
  input logic [PRG_W-1:0] b_program,
  input logic [SWL_W-1:0] a_swallow,
  input logic [SWL_W-1:0] b_swallow,
  input logic             cfg_err
);
  p_ref_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ref_ratio >= REF_W'(MIN_DIV)) && (b_ref_ratio >= REF_W'(MIN_DIV)));

  p_prog_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_program >= PRG_W'(MIN_DIV)) && (b_program >= PRG_W'(MIN_DIV)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ser_le) |=> ($stable(a_ref_ratio) && $stable(b_ref_ratio)));

  p_main_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ser_le) |=> ($stable(a_program) && $stable(b_program) &&
                        $stable(a_swallow) && $stable(b_swallow)));
endmodule

bind synth_prog_loader synth_prog_loader_chk #(
  .REF_W(REF_W), .SWL_W(SWL_W), .PRG_W(PRG_W), .MIN_DIV(MIN_DIV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_le(ser_le),
  .a_ref_ratio(a_ref_ratio), .b_ref_ratio(b_ref_ratio),
  .a_program(a_program), .b_program(b_program),
  .a_swallow(a_swallow), .b_swallow(b_swallow),
  .cfg_err(cfg_err)
);

// File: tb/synth_prog_loader_tb_top.sv
module synth_prog_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [13:0] a_ref_ratio, b_ref_ratio;
  logic [1:0]  a_test_sel, b_test_sel;
  logic [6:0]  a_swallow, b_swallow;
  logic [10:0] a_program, b_program;
  logic a_presc_hi, a_pol_inv, a_mon_sel, b_presc_hi, b_pol_inv, b_mon_sel, cfg_err;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  synth_prog_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .a_ref_ratio(a_ref_ratio), .a_test_sel(a_test_sel), .a_swallow(a_swallow),
    .a_program(a_program), .a_presc_hi(a_presc_hi), .a_pol_inv(a_pol_inv),
    .a_mon_sel(a_mon_sel), .b_ref_ratio(b_ref_ratio), .b_test_sel(b_test_sel),
    .b_swallow(b_swallow), .b_program(b_program), .b_presc_hi(b_presc_hi),
    .b_pol_inv(b_pol_inv), .b_mon_sel(b_mon_sel), .cfg_err(cfg_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [22:0] ref_word(bit ch, bit t1, bit t2, logic [13:0] r);
    return {5'b10110, r, t2, t1, 1'b0, ch};
  endfunction

  function automatic logic [22:0] main_word(bit ch, bit mon, bit psc, bit pol,
                                             logic [6:0] a, logic [10:0] n);
    return {n, a, pol, psc, mon, 1'b1, ch};
  endfunction

  task automatic shift_word(logic [22:0] w);
    for (int i = 22; i >= 0; i--) begin
      @(negedge clk); ser_dat = w[i]; ser_clk = 1'b0;
      @(negedge clk); ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    @(negedge clk); ser_le = 1'b1;
    repeat (2) @(negedge clk);
    ser_le = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(logic [22:0] w);
    shift_word(w);
    strobe();
  endtask

  task automatic t_reset();
    check("R8 a_ref", 32'(a_ref_ratio), 5);
    check("R8 b_ref", 32'(b_ref_ratio), 5);
    check("R8 a_prog", 32'(a_program), 5);
    check("R8 b_prog", 32'(b_program), 5);
    check("R8 swallow", 32'({a_swallow, b_swallow}), 0);
    check("R8 modes", 32'({a_test_sel, b_test_sel, a_presc_hi, a_pol_inv, a_mon_sel,
                           b_presc_hi, b_pol_inv, b_mon_sel}), 0);
    check("R8 err", 32'(cfg_err), 0);
  endtask

  task automatic t_ref_loads();
    send(ref_word(1'b0, 1'b1, 1'b0, 14'd1234));
    check("R1 R3 a_ref", 32'(a_ref_ratio), 1234);
    check("R3 a_test_sel", 32'(a_test_sel), 1);
    check("R2 b_ref untouched", 32'(b_ref_ratio), 5);
    check("R2 a_prog untouched", 32'(a_program), 5);
    send(ref_word(1'b1, 1'b0, 1'b1, 14'd16383));
    check("R10 b_ref max", 32'(b_ref_ratio), 16383);
    check("R3 b_test_sel", 32'(b_test_sel), 2);
    check("R2 a_ref kept", 32'(a_ref_ratio), 1234);
    send(ref_word(1'b1, 1'b0, 1'b0, 14'd5));
    check("R10 b_ref min", 32'(b_ref_ratio), 5);
    check("R5 no err on 5", 32'(cfg_err), 0);
  endtask

  task automatic t_main_loads();
    send(main_word(1'b0, 1'b1, 1'b0, 1'b1, 7'd127, 11'd2047));
    check("R4 R10 a_prog", 32'(a_program), 2047);
    check("R4 R6 a_swallow", 32'(a_swallow), 127);
    check("R4 a_modes", 32'({a_mon_sel, a_presc_hi, a_pol_inv}), 3'b101);
    check("R2 b_prog untouched", 32'(b_program), 5);
    check("R2 a_ref kept", 32'(a_ref_ratio), 1234);
    send(main_word(1'b1, 1'b0, 1'b1, 1'b0, 7'd0, 11'd5));
    check("R6 b_swallow 0", 32'(b_swallow), 0);
    check("R4 b_prog", 32'(b_program), 5);
    check("R4 b_modes", 32'({b_mon_sel, b_presc_hi, b_pol_inv}), 3'b010);
    check("R6 no err", 32'(cfg_err), 0);
  endtask

  task automatic t_reject();
    send(ref_word(1'b0, 1'b0, 1'b0, 14'd4));
    check("R5 a_ref kept", 32'(a_ref_ratio), 1234);
    check("R5 test_sel kept", 32'(a_test_sel), 1);
    check("R5 err set", 32'(cfg_err), 1);
    send(main_word(1'b1, 1'b1, 1'b1, 1'b1, 7'd9, 11'd3));
    check("R6 b_prog kept", 32'(b_program), 5);
    check("R6 b_swallow kept", 32'(b_swallow), 0);
    send(ref_word(1'b1, 1'b0, 1'b0, 14'd300));
    check("R9 good load taken", 32'(b_ref_ratio), 300);
    check("R9 err sticky", 32'(cfg_err), 1);
  endtask

  task automatic t_le_hold();
    @(negedge clk); ser_le = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 first rise", 32'(b_ref_ratio), 300);
    shift_word(ref_word(1'b0, 1'b0, 1'b1, 14'd777));
    repeat (2) @(negedge clk);
    check("R7 no write while high", 32'(a_ref_ratio), 1234);
    ser_le = 1'b0;
    @(negedge clk);
    check("R7 no write on fall", 32'(a_ref_ratio), 1234);
    strobe();
    check("R7 write on next rise", 32'(a_ref_ratio), 777);
    check("R3 test_sel T2", 32'(a_test_sel), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ref_loads();
    t_main_loads();
    t_reject();
    t_le_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule